// File: doc/BRIEF.md
# Split-Mode Warp Instruction Buffer

This block holds fetched instruction words for every warp of a SIMT core, ahead of issue. Each warp owns a fixed pool of slots built from two equal halves. While a warp runs as a single thread group, the two halves form one in-order queue of full capacity. After the warp splits into two sub-streams, each half serves one sub-stream by itself, with half the capacity.

For each stream the block keeps an active flag, the PC it expects next and the PC that fetch has already requested up to. It accepts an instruction only if that instruction continues the expected PC sequence. It reports whether fetch may request another group: the lines already requested but not yet delivered, the words already buffered and one new group must all fit in the stream's capacity. Control commands enable, disable, redirect or split a warp, and every command discards what that warp had buffered.

A stream is selected by a 2-bit code: 0 is the merged stream, 1 is sub-stream A, 2 is sub-stream B and 3 is reserved. The enqueue, dequeue, fetch-PC write and query ports all use this code.

Top module: `warp_ibuf`

## Requirements
- R1: After reset every warp is merged and inactive. A query of stream 0 shows it legal, inactive, count 0 and PCs 0. `enqReady` and `deqValid` are 0.
- R2: Command 0 (enable) puts the warp in merged mode, makes stream 0 active, loads both its next PC and its fetch PC with `ctlPcA` and empties its storage.
- R3: `enqReady` is 1 only when the selected stream is legal, active and not full, and `enqPc` equals its next PC. Each accepted word advances that next PC by 4.
- R4: A merged stream holds 8 words (both halves) and is full only when it holds 8. It returns its words in the order they were accepted.
- R5: After a split, sub-streams A and B each hold at most 4 words and fill and drain independently of each other.
- R6: A stream code is legal when it is 0 on a merged warp, or 1 or 2 on a split warp. Code 3 is never legal. For an illegal code `qLegal`, every other query output, `enqReady` and `deqValid` are 0.
- R7: `qFetchOk` is 1 exactly when the stream is legal and active and ((fetch PC − next PC)/4) + count + 2 ≤ capacity. The capacity is 8 for the merged stream and 4 for a sub-stream.
- R8: A fetch-PC write on a legal stream replaces its fetch PC. An accepted word sets the fetch PC to the larger of the new next PC and the fetch PC, where the fetch PC is the one being written in that cycle if there is one.
- R9: Command 2 (redirect) behaves like enable with target `ctlPcA`. Command 3 (split) makes the warp split, activates A at `ctlPcA` and B at `ctlPcB`, and empties both halves.
- R10: Command 1 (disable) makes the warp merged and inactive and empties it. Its PCs are kept, and enqueue is refused afterwards.
- R11: In a cycle with a command for warp w, enqueue, dequeue and fetch-PC writes that target w are refused (`enqReady`=0, `deqValid`=0).
- R12: `deqValid` is 1 when the selected stream is legal and holds at least one word. `deqPc`/`deqInstr` show its oldest word, which is removed when `deqReady` is also 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctlValid | input | 1 | Command strobe |
| ctlCmd | input | 2 | 0 enable, 1 disable, 2 redirect, 3 split |
| ctlWarp | input | 3 | Warp the command targets |
| ctlPcA | input | 32 | Target PC (merged stream or sub-stream A) |
| ctlPcB | input | 32 | Target PC of sub-stream B |
| enqValid | input | 1 | Word offered |
| enqReady | output | 1 | Word would be accepted |
| enqWarp | input | 3 | Warp of offered word |
| enqStream | input | 2 | Stream code of offered word |
| enqPc | input | 32 | PC of offered word |
| enqInstr | input | 32 | Instruction word |
| deqReady | input | 1 | Consumer takes the head word |
| deqValid | output | 1 | Head word present |
| deqWarp | input | 3 | Warp to read |
| deqStream | input | 2 | Stream code to read |
| deqPc | output | 32 | PC of head word |
| deqInstr | output | 32 | Head instruction word |
| fpValid | input | 1 | Fetch-PC write strobe |
| fpWarp | input | 3 | Warp of fetch-PC write |
| fpStream | input | 2 | Stream code of fetch-PC write |
| fpPc | input | 32 | New fetch PC |
| qWarp | input | 3 | Warp to query |
| qStream | input | 2 | Stream code to query |
| qLegal | output | 1 | Stream code legal in current mode |
| qActive | output | 1 | Stream active |
| qCount | output | 4 | Buffered words |
| qFull | output | 1 | Stream full |
| qEmpty | output | 1 | Stream empty (0 when illegal) |
| qNextPc | output | 32 | Expected next PC |
| qFetchPc | output | 32 | Fetch-ahead PC |
| qFetchOk | output | 1 | Room for another fetch group |

## Verification
The bench fills a merged stream across the point where the first half runs out and then drains it. A design that filled or drained the two halves in the wrong order would return the PCs out of sequence. It checks the fetch-credit result on both sides of the limit, once with fetch running ahead of the next PC. An off-by-one or a wrong capacity in split mode would flip `qFetchOk` there. It offers out-of-sequence PCs and illegal stream codes, queries code 3, and fills one sub-stream while checking that the other still accepts. A design with shared occupancy or a loose legality check would accept where it must refuse. It also sends a disable in the same cycle as an enqueue to the same warp, and a design that let the write through would report a non-zero count.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
  localparam int unsigned NUM_WARPS   = 8;
  localparam int unsigned WARP_CAP    = 8;
  localparam int unsigned FETCH_WIDTH = 2;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned INSTR_W     = 32;
  localparam int unsigned WID_W       = $clog2(NUM_WARPS);

  typedef enum logic [1:0] {
    CMD_ENABLE  = 2'd0,
    CMD_DISABLE = 2'd1,
    CMD_JUMP    = 2'd2,
    CMD_SPLIT   = 2'd3
  } ctlCmd_e;

  typedef struct packed {
    logic [INSTR_W-1:0] instr;
    logic [ADDR_W-1:0]  pc;
  } entry_t;

  // strobes from control to storage
  typedef struct packed {
    logic             push;
    logic [WID_W-1:0] pushWarp;
    logic             pushHalf;
    logic             pop;
    logic [WID_W-1:0] popWarp;
    logic             popHalf;
    logic             flush;
    logic [WID_W-1:0] flushWarp;
  } storeCtl_t;
endpackage

// File: rtl/ibuf_store.sv
module ibuf_store
  import ibuf_pkg::*;
#(
  parameter int unsigned NW   = NUM_WARPS,
  parameter int unsigned HALF = WARP_CAP / 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  storeCtl_t                sc,
  input  entry_t                   wrData,
  input  logic [WID_W-1:0]         rdWarp,
  input  logic                     rdHalf,
  output logic [$clog2(HALF+1)-1:0] fill [NW][2],
  output entry_t                   head
);
  localparam int unsigned PW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int unsigned CW = $clog2(HALF + 1);

  entry_t headAll [NW][2];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(HALF - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar w = 0; w < NW; w++) begin : g_warp
    for (genvar h = 0; h < 2; h++) begin : g_half
      entry_t          slot [HALF];
      logic [PW-1:0]   wrPtr, rdPtr;
      logic [CW-1:0]   cnt;
      logic            doPush, doPop, doFlush;

      assign doPush  = sc.push && (sc.pushWarp == WID_W'(w)) && (sc.pushHalf == 1'(h));
      assign doPop   = sc.pop  && (sc.popWarp  == WID_W'(w)) && (sc.popHalf  == 1'(h));
      assign doFlush = sc.flush && (sc.flushWarp == WID_W'(w));

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          wrPtr <= '0;
          rdPtr <= '0;
          cnt   <= '0;
        end else if (doFlush) begin
          wrPtr <= '0;
          rdPtr <= '0;
          cnt   <= '0;
        end else begin
          if (doPush) wrPtr <= bump(wrPtr);
          if (doPop)  rdPtr <= bump(rdPtr);
          cnt <= cnt + CW'(doPush) - CW'(doPop);
        end
      end

      always_ff @(posedge clk) begin
        if (doPush) slot[wrPtr] <= wrData;
      end

      assign fill[w][h]    = cnt;
      assign headAll[w][h] = slot[rdPtr];

      // R4 / R5: control never writes into a full half
      a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
        doPush |-> (cnt < CW'(HALF)));
      // R12: control never removes from an empty half
      a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
        doPop |-> (cnt != '0));
    end
  end

  assign head = headAll[rdWarp][rdHalf];
endmodule

// File: rtl/ibuf_ctrl.sv
module ibuf_ctrl
  import ibuf_pkg::*;
#(
  parameter int unsigned NW  = NUM_WARPS,
  parameter int unsigned CAP = WARP_CAP,
  parameter int unsigned FW  = FETCH_WIDTH,
  parameter int unsigned AW  = ADDR_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     ctlValid,
  input  logic [1:0]               ctlCmd,
  input  logic [WID_W-1:0]         ctlWarp,
  input  logic [AW-1:0]            ctlPcA,
  input  logic [AW-1:0]            ctlPcB,
  input  logic                     enqValid,
  output logic                     enqReady,
  input  logic [WID_W-1:0]         enqWarp,
  input  logic [1:0]               enqStream,
  input  logic [AW-1:0]            enqPc,
  input  logic                     deqReady,
  output logic                     deqValid,
  input  logic [WID_W-1:0]         deqWarp,
  input  logic [1:0]               deqStream,
  input  logic                     fpValid,
  input  logic [WID_W-1:0]         fpWarp,
  input  logic [1:0]               fpStream,
  input  logic [AW-1:0]            fpPc,
  input  logic [WID_W-1:0]         qWarp,
  input  logic [1:0]               qStream,
  output logic                     qLegal,
  output logic                     qActive,
  output logic [$clog2(CAP+1)-1:0] qCount,
  output logic                     qFull,
  output logic                     qEmpty,
  output logic [AW-1:0]            qNextPc,
  output logic [AW-1:0]            qFetchPc,
  output logic                     qFetchOk,
  input  logic [$clog2(CAP/2+1)-1:0] fill [NW][2],
  output storeCtl_t                sc,
  output logic [WID_W-1:0]         rdWarp,
  output logic                     rdHalf
);
  localparam int unsigned HALF = CAP / 2;
  localparam int unsigned CW   = $clog2(HALF + 1);
  localparam int unsigned OW   = $clog2(CAP + 1);
  localparam int unsigned NDW  = AW + 1;

  logic          divA   [NW];
  logic          actA   [NW][2];
  logic [AW-1:0] nextPcA  [NW][2];
  logic [AW-1:0] fetchPcA [NW][2];
  logic          wrSideA [NW];
  logic          rdSideA [NW];

  function automatic logic selLegal(input logic d, input logic [1:0] s);
    return (s == 2'd0) ? !d : ((s == 2'd1 || s == 2'd2) && d);
  endfunction

  function automatic logic [OW-1:0] occOf(input logic [CW-1:0] f0, input logic [CW-1:0] f1,
                                          input logic [1:0] s);
    if (s == 2'd0) return OW'(f0) + OW'(f1);
    return s[1] ? OW'(f1) : OW'(f0);
  endfunction

  function automatic logic [AW-1:0] maxPc(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // ---------------- query ----------------
  logic [OW-1:0]  qOcc;
  logic [AW-1:0]  qDist;
  logic [NDW-1:0] qNeed;
  logic           qi;
  always_comb begin
    qi       = qStream[1];
    qLegal   = selLegal(divA[qWarp], qStream);
    qOcc     = occOf(fill[qWarp][0], fill[qWarp][1], qStream);
    qDist    = (fetchPcA[qWarp][qi] - nextPcA[qWarp][qi]) >> 2;
    qNeed    = NDW'(qDist) + NDW'(qOcc) + NDW'(FW);
    qActive  = qLegal && actA[qWarp][qi];
    qCount   = qLegal ? qOcc : '0;
    qFull    = qLegal && (qOcc == ((qStream == 2'd0) ? OW'(CAP) : OW'(HALF)));
    qEmpty   = qLegal && (qOcc == '0);
    qNextPc  = qLegal ? nextPcA[qWarp][qi]  : '0;
    qFetchPc = qLegal ? fetchPcA[qWarp][qi] : '0;
    qFetchOk = qActive && (qNeed <= ((qStream == 2'd0) ? NDW'(CAP) : NDW'(HALF)));
  end

  // ---------------- enqueue / dequeue / fetch-pc ----------------
  logic [OW-1:0] eOcc, dOcc;
  logic eLegal, eFull, dLegal, fpHit, push, pop;
  always_comb begin
    eLegal   = selLegal(divA[enqWarp], enqStream);
    eOcc     = occOf(fill[enqWarp][0], fill[enqWarp][1], enqStream);
    eFull    = (eOcc == ((enqStream == 2'd0) ? OW'(CAP) : OW'(HALF)));
    enqReady = eLegal && actA[enqWarp][enqStream[1]] && !eFull &&
               (enqPc == nextPcA[enqWarp][enqStream[1]]) &&
               !(ctlValid && ctlWarp == enqWarp);
    push     = enqValid && enqReady;

    dLegal   = selLegal(divA[deqWarp], deqStream);
    dOcc     = occOf(fill[deqWarp][0], fill[deqWarp][1], deqStream);
    deqValid = dLegal && (dOcc != '0) && !(ctlValid && ctlWarp == deqWarp);
    pop      = deqValid && deqReady;
    rdWarp   = deqWarp;
    rdHalf   = (deqStream == 2'd0) ? rdSideA[deqWarp] : deqStream[1];

    fpHit    = fpValid && selLegal(divA[fpWarp], fpStream) && !(ctlValid && ctlWarp == fpWarp);

    sc.push      = push;
    sc.pushWarp  = enqWarp;
    sc.pushHalf  = (enqStream == 2'd0) ? wrSideA[enqWarp] : enqStream[1];
    sc.pop       = pop;
    sc.popWarp   = deqWarp;
    sc.popHalf   = rdHalf;
    sc.flush     = ctlValid;
    sc.flushWarp = ctlWarp;
  end

  // ---------------- per-warp stream state ----------------
  for (genvar w = 0; w < NW; w++) begin : g_warp
    logic          div, divD, ws, wsD, rs, rsD;
    logic          act [2];
    logic          actD [2];
    logic [AW-1:0] nxt [2];
    logic [AW-1:0] nxtD [2];
    logic [AW-1:0] fch [2];
    logic [AW-1:0] fchD [2];
    logic          mine;

    assign mine = ctlValid && (ctlWarp == WID_W'(w));

    always_comb begin
      divD = div; wsD = ws; rsD = rs;
      actD = act; nxtD = nxt; fchD = fch;
      if (mine) begin
        wsD = 1'b0;
        rsD = 1'b0;
        unique case (ctlCmd)
          CMD_ENABLE, CMD_JUMP: begin
            divD = 1'b0; actD[0] = 1'b1; actD[1] = 1'b0;
            nxtD[0] = ctlPcA; fchD[0] = ctlPcA;
          end
          CMD_DISABLE: begin
            divD = 1'b0; actD[0] = 1'b0; actD[1] = 1'b0;
          end
          default: begin
            divD = 1'b1; actD[0] = 1'b1; actD[1] = 1'b1;
            nxtD[0] = ctlPcA; fchD[0] = ctlPcA;
            nxtD[1] = ctlPcB; fchD[1] = ctlPcB;
          end
        endcase
      end else begin
        for (int i = 0; i < 2; i++) begin
          if (push && enqWarp == WID_W'(w) && enqStream[1] == 1'(i)) begin
            nxtD[i] = enqPc + AW'(4);
            fchD[i] = maxPc(enqPc + AW'(4),
                            (fpHit && fpWarp == WID_W'(w) && fpStream[1] == 1'(i)) ? fpPc : fch[i]);
          end else if (fpHit && fpWarp == WID_W'(w) && fpStream[1] == 1'(i)) begin
            fchD[i] = fpPc;
          end
        end
        if (push && enqWarp == WID_W'(w) && enqStream == 2'd0) wsD = !ws;
        if (pop  && deqWarp == WID_W'(w) && deqStream == 2'd0) rsD = !rs;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        div <= 1'b0; ws <= 1'b0; rs <= 1'b0;
        act <= '{default: 1'b0};
        nxt <= '{default: '0};
        fch <= '{default: '0};
      end else begin
        div <= divD; ws <= wsD; rs <= rsD;
        act <= actD; nxt <= nxtD; fch <= fchD;
      end
    end

    assign divA[w] = div;
    assign wrSideA[w] = ws;
    assign rdSideA[w] = rs;
    for (genvar i = 0; i < 2; i++) begin : g_s
      assign actA[w][i]     = act[i];
      assign nextPcA[w][i]  = nxt[i];
      assign fetchPcA[w][i] = fch[i];
    end
  end

  // R3: an accepted word moves the expected PC one word on
  a_r3_next_advance: assert property (@(posedge clk) disable iff (!rstN)
    push |=> (nextPcA[$past(enqWarp)][$past(enqStream[1])] == $past(enqPc) + AW'(4)));
  // R11: a command for a warp locks out its enqueue that cycle
  a_r11_ctl_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && ctlWarp == enqWarp) |-> !enqReady);
  // R6: illegal selection reports nothing
  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !qLegal |-> (qCount == '0 && !qActive && !qFetchOk && !qFull));
  // R10: disable leaves both streams inactive
  a_r10_disable_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ctlValid && ctlCmd == CMD_DISABLE) |=>
      (!actA[$past(ctlWarp)][0] && !actA[$past(ctlWarp)][1]));
endmodule

// File: rtl/warp_ibuf.sv
module warp_ibuf
  import ibuf_pkg::*;
#(
  parameter int unsigned NW  = NUM_WARPS,
  parameter int unsigned CAP = WARP_CAP,
  parameter int unsigned FW  = FETCH_WIDTH,
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned IW  = INSTR_W,
  localparam int unsigned WW = $clog2(NW),
  localparam int unsigned OW = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlValid,
  input  logic [1:0]    ctlCmd,
  input  logic [WW-1:0] ctlWarp,
  input  logic [AW-1:0] ctlPcA,
  input  logic [AW-1:0] ctlPcB,
  input  logic          enqValid,
  output logic          enqReady,
  input  logic [WW-1:0] enqWarp,
  input  logic [1:0]    enqStream,
  input  logic [AW-1:0] enqPc,
  input  logic [IW-1:0] enqInstr,
  input  logic          deqReady,
  output logic          deqValid,
  input  logic [WW-1:0] deqWarp,
  input  logic [1:0]    deqStream,
  output logic [AW-1:0] deqPc,
  output logic [IW-1:0] deqInstr,
  input  logic          fpValid,
  input  logic [WW-1:0] fpWarp,
  input  logic [1:0]    fpStream,
  input  logic [AW-1:0] fpPc,
  input  logic [WW-1:0] qWarp,
  input  logic [1:0]    qStream,
  output logic          qLegal,
  output logic          qActive,
  output logic [OW-1:0] qCount,
  output logic          qFull,
  output logic          qEmpty,
  output logic [AW-1:0] qNextPc,
  output logic [AW-1:0] qFetchPc,
  output logic          qFetchOk
);
  localparam int unsigned CW = $clog2(CAP / 2 + 1);

  storeCtl_t     sc;
  logic [CW-1:0] fillW [NW][2];
  logic [WW-1:0] rdWarp;
  logic          rdHalf;
  entry_t        head;
  entry_t        wrData;

  assign wrData   = '{instr: enqInstr, pc: enqPc};
  assign deqPc    = head.pc;
  assign deqInstr = head.instr;

  ibuf_ctrl #(.NW(NW), .CAP(CAP), .FW(FW), .AW(AW)) ctrl_i (
    .clk, .rstN, .ctlValid, .ctlCmd, .ctlWarp, .ctlPcA, .ctlPcB,
    .enqValid, .enqReady, .enqWarp, .enqStream, .enqPc,
    .deqReady, .deqValid, .deqWarp, .deqStream,
    .fpValid, .fpWarp, .fpStream, .fpPc,
    .qWarp, .qStream, .qLegal, .qActive, .qCount, .qFull, .qEmpty,
    .qNextPc, .qFetchPc, .qFetchOk,
    .fill(fillW), .sc, .rdWarp, .rdHalf
  );

  ibuf_store #(.NW(NW), .HALF(CAP / 2)) store_i (
    .clk, .rstN, .sc, .wrData, .rdWarp, .rdHalf, .fill(fillW), .head
  );
endmodule

// File: tb/warp_ibuf_tb.sv
module warp_ibuf_tb_top;
  logic clk = 1'b0, rstN = 1'b0;
  logic ctlValid = 0; logic [1:0] ctlCmd = 0; logic [2:0] ctlWarp = 0;
  logic [31:0] ctlPcA = 0, ctlPcB = 0;
  logic enqValid = 0, enqReady; logic [2:0] enqWarp = 0; logic [1:0] enqStream = 0;
  logic [31:0] enqPc = 0, enqInstr = 0;
  logic deqReady = 0, deqValid; logic [2:0] deqWarp = 0; logic [1:0] deqStream = 0;
  logic [31:0] deqPc, deqInstr;
  logic fpValid = 0; logic [2:0] fpWarp = 0; logic [1:0] fpStream = 0; logic [31:0] fpPc = 0;
  logic [2:0] qWarp = 0; logic [1:0] qStream = 0;
  logic qLegal, qActive, qFull, qEmpty, qFetchOk; logic [3:0] qCount;
  logic [31:0] qNextPc, qFetchPc;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  warp_ibuf dut_i (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic ctl(input logic [1:0] cmd, input logic [2:0] w, input logic [31:0] a, input logic [31:0] b);
    ctlValid = 1; ctlCmd = cmd; ctlWarp = w; ctlPcA = a; ctlPcB = b;
    tick(); ctlValid = 0;
  endtask

  task automatic enq(input string req, input logic [2:0] w, input logic [1:0] s, input logic [31:0] pc,
                     input logic [31:0] ins, input logic expRdy);
    enqValid = 1; enqWarp = w; enqStream = s; enqPc = pc; enqInstr = ins;
    #2 chk(req, "enqReady", enqReady, expRdy);
    tick(); enqValid = 0;
  endtask

  task automatic deq(input string req, input logic [2:0] w, input logic [1:0] s, input logic expV,
                     input logic [31:0] pc, input logic [31:0] ins);
    deqReady = 1; deqWarp = w; deqStream = s;
    #2 chk(req, "deqValid", deqValid, expV);
    if (expV) begin
      chk(req, "deqPc", deqPc, pc);
      chk(req, "deqInstr", deqInstr, ins);
    end
    tick(); deqReady = 0;
  endtask

  task automatic fpw(input logic [2:0] w, input logic [1:0] s, input logic [31:0] pc);
    fpValid = 1; fpWarp = w; fpStream = s; fpPc = pc;
    tick(); fpValid = 0;
  endtask

  task automatic q(input string req, input logic [2:0] w, input logic [1:0] s, input logic lg, input logic ac,
                   input logic [3:0] cnt, input logic [31:0] np, input logic [31:0] fp, input logic ok);
    qWarp = w; qStream = s;
    #2;
    chk(req, "qLegal", qLegal, lg);
    chk(req, "qActive", qActive, ac);
    chk(req, "qCount", qCount, cnt);
    chk(req, "qNextPc", qNextPc, np);
    chk(req, "qFetchPc", qFetchPc, fp);
    chk(req, "qFetchOk", qFetchOk, ok);
  endtask

  task automatic testReset();
    q("R1", 0, 0, 1, 0, 0, 0, 0, 0);
    chk("R1", "qEmpty", qEmpty, 1);
    enq("R1", 0, 0, 32'h0, 32'h0, 0);
    deq("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic testEnable();
    ctl(2'd0, 1, 32'h100, 0);
    q("R2", 1, 0, 1, 1, 0, 32'h100, 32'h100, 1);
  endtask

  task automatic testMergedFill();
    enq("R3", 1, 0, 32'h104, 32'h0, 0);               // out of sequence
    for (int i = 0; i < 8; i++) begin
      enq("R3", 1, 0, 32'h100 + 4 * i, 32'hA000 + i, 1);
      q("R7", 1, 0, 1, 1, 4'(i + 1), 32'h104 + 4 * i, 32'h104 + 4 * i, (i + 1 + 2) <= 8);
    end
    chk("R4", "qFull", qFull, 1);
    enq("R4", 1, 0, 32'h120, 32'h0, 0);
  endtask

  task automatic testMergedDrain();
    for (int i = 0; i < 8; i++) deq("R4", 1, 0, 1, 32'h100 + 4 * i, 32'hA000 + i);
    deq("R12", 1, 0, 0, 0, 0);
  endtask

  task automatic testFetchCredit();
    fpw(1, 0, 32'h13c);
    q("R7", 1, 0, 1, 1, 0, 32'h120, 32'h13c, 0);      // 7+0+2 > 8
    fpw(1, 0, 32'h138);
    q("R7", 1, 0, 1, 1, 0, 32'h120, 32'h138, 1);      // 6+0+2 = 8
    enq("R8", 1, 0, 32'h120, 32'hB0, 1);
    q("R8", 1, 0, 1, 1, 1, 32'h124, 32'h138, 1);      // 5+1+2 = 8
    fpw(1, 0, 32'h100);
    enq("R8", 1, 0, 32'h124, 32'hB1, 1);
    q("R8", 1, 0, 1, 1, 2, 32'h128, 32'h128, 1);
  endtask

  task automatic testSplit();
    ctl(2'd3, 1, 32'h200, 32'h300);
    q("R6", 1, 0, 0, 0, 0, 0, 0, 0);
    q("R6", 1, 3, 0, 0, 0, 0, 0, 0);
    q("R9", 1, 1, 1, 1, 0, 32'h200, 32'h200, 1);
    q("R9", 1, 2, 1, 1, 0, 32'h300, 32'h300, 1);
    enq("R6", 1, 0, 32'h200, 32'h0, 0);
    for (int i = 0; i < 4; i++) begin
      enq("R5", 1, 1, 32'h200 + 4 * i, 32'hC000 + i, 1);
      q("R7", 1, 1, 1, 1, 4'(i + 1), 32'h204 + 4 * i, 32'h204 + 4 * i, (i + 1 + 2) <= 4);
    end
    chk("R5", "qFull", qFull, 1);
    enq("R5", 1, 1, 32'h210, 32'h0, 0);
    enq("R5", 1, 2, 32'h300, 32'hD000, 1);
    q("R5", 1, 2, 1, 1, 1, 32'h304, 32'h304, 1);
    q("R5", 1, 1, 1, 1, 4, 32'h210, 32'h210, 0);
    deq("R12", 1, 2, 1, 32'h300, 32'hD000);
    deq("R12", 1, 2, 0, 0, 0);
    deq("R12", 1, 1, 1, 32'h200, 32'hC000);
  endtask

  task automatic testCtlBlock();
    enqValid = 1; enqWarp = 1; enqStream = 1; enqPc = 32'h210; enqInstr = 32'hE0;
    ctlValid = 1; ctlCmd = 2'd1; ctlWarp = 1;
    #2 chk("R11", "enqReady", enqReady, 0);
    tick(); enqValid = 0; ctlValid = 0;
    q("R10", 1, 0, 1, 0, 0, 32'h210, 32'h210, 0);
    enq("R10", 1, 0, 32'h210, 32'h0, 0);
    deq("R10", 1, 0, 0, 0, 0);
  endtask

  task automatic testRedirect();
    ctl(2'd0, 7, 32'h400, 0);
    enq("R3", 7, 0, 32'h400, 32'hF0, 1);
    enq("R3", 7, 0, 32'h404, 32'hF1, 1);
    ctl(2'd2, 7, 32'h500, 0);
    q("R9", 7, 0, 1, 1, 0, 32'h500, 32'h500, 1);
    deq("R9", 7, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testEnable();
    testMergedFill();
    testMergedDrain();
    testFetchCredit();
    testSplit();
    testCtlBlock();
    testRedirect();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog all requirements act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule